// File: doc/BRIEF.md
# Microcontroller Mailbox Host Port

This block is the host side of a byte mailbox between a processor and a system-management microcontroller. The processor reaches it through a small word-addressed register window. Bytes the host writes go into a transmit FIFO, and the block offers them to the microcontroller as a byte-wide valid/ready stream. Bytes the microcontroller sends arrive as a byte-wide strobed stream and queue in a receive FIFO until the host reads them.

Four FIFO conditions are visible as live status bits: transmit empty, transmit has room, receive holds data, and receive overflowed. Each condition also has a latched request flag and an enable bit. The single interrupt line is high whenever an enabled request is pending. The host clears requests, and the sticky overflow flag, by writing ones to the status register. This lets a driver either poll status or sleep on the interrupt.

Top module: `mbox_host_port`

## Requirements
- R1: Word offsets decode as follows: 0 is interrupt control, 1 is data and 2 is status. Offsets 3 to 7 are reserved. A reserved offset reads as zero, and a write to it changes nothing.
- R2: After reset both FIFOs are empty and all masks and requests are zero. Interrupt control reads 0x00, status reads 0x3, `irq` is low and `txValid` is low.
- R3: A write to the data register pushes busWdata[15:8] into the transmit FIFO. The microcontroller sees the bytes in write order on `txData` while `txValid` is high. A byte leaves the FIFO on each clock edge where `txValid` and `txReady` are both high.
- R4: Each FIFO holds 16 bytes. A data write while the transmit FIFO holds 16 bytes is ignored and leaves the queued bytes intact.
- R5: A byte on `rxData` with `rxValid` high enters the receive FIFO. A data read returns the oldest received byte in bits 15:8, with all other bits zero, and removes that byte. A data read from an empty receive FIFO returns zero.
- R6: A byte that arrives while the receive FIFO is full is discarded and sets a sticky overflow flag. The flag stays set until it is cleared by a one in status bit 3.
- R7: Status bit 0 shows transmit empty, bit 1 shows transmit not full, bit 2 shows receive not empty and bit 3 shows the overflow flag. Bits 31:4 read zero.
- R8: Interrupt-control bits 3:0 are request flags for the status conditions in the same bit order. Flags 0 to 2 latch one clock after their condition goes from false to true. Flag 3 latches on each discarded byte. A flag stays set until it is cleared.
- R9: Writing the status register with bit n set clears request flag n. Bit 3 also clears the overflow flag. Zero bits leave their flags unchanged. A new set event in the same cycle takes priority over the clear.
- R10: Interrupt-control bits 7:4 are enable bits that the host can write. A write to bits 3:0 there has no effect. `irq` is high exactly when some request flag and its enable bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Bus access this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Word offset in the window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the same cycle as the access |
| txData | output | 8 | Head byte of the transmit FIFO |
| txValid | output | 1 | Transmit FIFO is not empty |
| txReady | input | 1 | Microcontroller takes the byte |
| rxData | input | 8 | Byte from the microcontroller |
| rxValid | input | 1 | rxData carries a byte this cycle |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills the receive FIFO past capacity. A design with an off-by-one depth, or one that overwrites on overflow, returns the wrong sixteenth byte or a seventeenth byte. It also fills the transmit FIFO to 16 and writes once more; a design that does not guard the full case corrupts the queue or shows an extra byte. The bench checks that requests latch on a rising condition only, so a level-latching design would show the transmit-empty request right after reset. It also checks that the write-one-to-clear and the mask writes touch only the bits they name, so a design that cleared the overflow flag on any status write, or let interrupt-control writes set requests, gives wrong register values or a wrong interrupt level.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int unsigned NUM_COND = 4;
  localparam int unsigned COND_TXE  = 0;
  localparam int unsigned COND_TXNF = 1;
  localparam int unsigned COND_RXNE = 2;
  localparam int unsigned COND_RXO  = 3;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_INTR = 2'd1,
    RD_DATA = 2'd2,
    RD_STAT = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   txPush;
    logic   rxPop;
    logic   maskWr;
    logic   statWr;
    rdSel_e rdSel;
  } strobes_t;

endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         push,
  input  logic [WIDTH-1:0]             pushData,
  input  logic                         pop,
  output logic [WIDTH-1:0]             head,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    wrPtr;
  logic [AW-1:0]    rdPtr;
  logic [CW-1:0]    fill;
  logic             doPush;
  logic             doPop;

  assign empty  = (fill == '0);
  assign full   = (fill == CW'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = store[rdPtr];
  assign count  = fill;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    full && push && !pop |=> $stable(count)); // R4

endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output strobes_t          stb
);
  localparam logic [ADDR_W-1:0] OFF_INTR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_DATA = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(2);

  always_comb begin
    stb = '0;
    if (busSel) begin
      unique case (busAddr)
        OFF_INTR: begin
          stb.maskWr = busWr;
          stb.rdSel  = busWr ? RD_ZERO : RD_INTR;
        end
        OFF_DATA: begin
          stb.txPush = busWr;
          stb.rxPop  = !busWr;
          stb.rdSel  = busWr ? RD_ZERO : RD_DATA;
        end
        OFF_STAT: begin
          stb.statWr = busWr;
          stb.rdSel  = busWr ? RD_ZERO : RD_STAT;
        end
        default: stb = '0;
      endcase
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.txPush, stb.rxPop, stb.maskWr, stb.statWr})); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |-> (stb == '0)); // R1

endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned BYTE_LSB   = 8,
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [BYTE_W-1:0] txData,
  output logic              txValid,
  input  logic              txReady,
  input  logic [BYTE_W-1:0] rxData,
  input  logic              rxValid,
  output logic              irq
);
  localparam int unsigned CW = $clog2(FIFO_DEPTH + 1);
  localparam int unsigned NEDGE = NUM_COND - 1;

  logic              txEmpty, txFull, rxEmpty, rxFull;
  logic [CW-1:0]     txCount, rxCount;
  logic [BYTE_W-1:0] rxHead;
  logic              txPop;
  logic              dropEvt;
  logic              ovfFlag;
  logic [NUM_COND-1:0] reqBits;
  logic [NUM_COND-1:0] maskBits;
  logic [NUM_COND-1:0] statusBits;
  logic [NUM_COND-1:0] clrBits;
  logic [NEDGE-1:0]  condPrev;
  logic [NEDGE-1:0]  condRise;
  logic [BYTE_W-1:0] wrByte;
  logic              unusedWdata;

  assign wrByte      = busWdata[BYTE_LSB +: BYTE_W];
  assign unusedWdata = ^{busWdata[DATA_W-1:BYTE_LSB+BYTE_W], busWdata[BYTE_LSB-1:2*NUM_COND]};
  assign txPop       = txValid && txReady;
  assign txValid     = !txEmpty;
  assign dropEvt     = rxValid && rxFull;

  mbox_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) uTxFifo (
    .clk(clk), .rstN(rstN),
    .push(stb.txPush), .pushData(wrByte),
    .pop(txPop), .head(txData),
    .empty(txEmpty), .full(txFull), .count(txCount)
  );

  mbox_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) uRxFifo (
    .clk(clk), .rstN(rstN),
    .push(rxValid), .pushData(rxData),
    .pop(stb.rxPop), .head(rxHead),
    .empty(rxEmpty), .full(rxFull), .count(rxCount)
  );

  // live conditions, in register bit order
  always_comb begin
    statusBits            = '0;
    statusBits[COND_TXE]  = txEmpty;
    statusBits[COND_TXNF] = !txFull;
    statusBits[COND_RXNE] = !rxEmpty;
    statusBits[COND_RXO]  = ovfFlag;
  end

  assign clrBits = stb.statWr ? busWdata[NUM_COND-1:0] : '0;

  // sticky overflow; a new drop outranks a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ovfFlag <= 1'b0;
    else if (dropEvt)       ovfFlag <= 1'b1;
    else if (clrBits[COND_RXO]) ovfFlag <= 1'b0;
  end

  // previous condition values; reset matches the empty-FIFO state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      condPrev <= NEDGE'(3'b011);
    end else begin
      condPrev <= statusBits[NEDGE-1:0];
    end
  end

  assign condRise = statusBits[NEDGE-1:0] & ~condPrev;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_COND; gi++) begin : gReq
      logic setEvt;
      if (gi == COND_RXO) begin : gOvf
        assign setEvt = dropEvt;
      end else begin : gEdge
        assign setEvt = condRise[gi];
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)           reqBits[gi] <= 1'b0;
        else if (setEvt)     reqBits[gi] <= 1'b1;
        else if (clrBits[gi]) reqBits[gi] <= 1'b0;
      end
      AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
        reqBits[gi] && !clrBits[gi] |=> reqBits[gi]); // R8
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           maskBits <= '0;
    else if (stb.maskWr) maskBits <= busWdata[2*NUM_COND-1:NUM_COND];
  end

  assign irq = |(reqBits & maskBits);

  always_comb begin
    busRdata = '0;
    unique case (stb.rdSel)
      RD_INTR: busRdata[2*NUM_COND-1:0] = {maskBits, reqBits};
      RD_STAT: busRdata[NUM_COND-1:0]   = statusBits;
      RD_DATA: if (!rxEmpty) busRdata[BYTE_LSB +: BYTE_W] = rxHead;
      default: busRdata = '0;
    endcase
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag && !clrBits[COND_RXO] |=> ovfFlag); // R6

  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    dropEvt |=> ovfFlag && reqBits[COND_RXO]); // R6

  AST_RXNE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqBits[COND_RXNE]) |-> $past(rxCount) != '0); // R8

  AST_TX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    txCount <= CW'(FIFO_DEPTH)); // R4

  AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rstN)
    maskBits == '0 |-> !irq); // R10

endmodule

// File: rtl/mbox_host_port.sv
module mbox_host_port
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned BYTE_LSB   = 8,
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [BYTE_W-1:0] txData,
  output logic              txValid,
  input  logic              txReady,
  input  logic [BYTE_W-1:0] rxData,
  input  logic              rxValid,
  output logic              irq
);
  strobes_t stb;

  mbox_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .stb(stb)
  );

  mbox_datapath #(
    .DATA_W(DATA_W), .BYTE_W(BYTE_W), .BYTE_LSB(BYTE_LSB), .FIFO_DEPTH(FIFO_DEPTH)
  ) uPath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .busWdata(busWdata), .busRdata(busRdata),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .rxData(rxData), .rxValid(rxValid), .irq(irq)
  );

endmodule

// File: tb/sim_mbox_host_port.sv
`timescale 1ns/100ps
module sim_mbox_host_port;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0]  txData;
  logic        txValid;
  logic        txReady = 1'b0;
  logic [7:0]  rxData = '0;
  logic        rxValid = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mbox_host_port u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .txData(txData), .txValid(txValid),
    .txReady(txReady), .rxData(rxData), .rxValid(rxValid), .irq(irq)
  );

  typedef struct packed {
    logic        isRead;
    logic [2:0]  addr;
    logic [31:0] wdata;
    logic [31:0] expect_;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 3'd2, 32'h0,        32'h3,  8'd2},  // R2 status after reset
    '{1'b1, 3'd0, 32'h0,        32'h0,  8'd2},  // R2 intr after reset
    '{1'b0, 3'd0, 32'hFF,       32'h0,  8'd10}, // R10 write masks and req bits
    '{1'b1, 3'd0, 32'h0,        32'hF0, 8'd10}, // R10 only masks took
    '{1'b1, 3'd5, 32'h0,        32'h0,  8'd1},  // R1 reserved read
    '{1'b0, 3'd6, 32'hFFFF,     32'h0,  8'd1},  // R1 reserved write
    '{1'b1, 3'd0, 32'h0,        32'hF0, 8'd1},  // R1 unchanged
    '{1'b1, 3'd1, 32'h0,        32'h0,  8'd5},  // R5 empty read
    '{1'b0, 3'd1, 32'h0000A500, 32'h0,  8'd3},  // R3 push A5
    '{1'b1, 3'd2, 32'h0,        32'h2,  8'd7},  // R7 tx not empty
    '{1'b0, 3'd1, 32'h12345C00, 32'h0,  8'd3},  // R3 push 5C
    '{1'b1, 3'd0, 32'h0,        32'hF0, 8'd8}   // R8 no rising edge yet
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp_, input string what);
    checks++;
    if (act !== exp_) begin
      errors++;
      $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", req, what, act, exp_);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic readCheck(input logic [2:0] a, input logic [31:0] exp_, input int req, input string what);
    logic [31:0] d;
    busRead(a, d);
    check(req, d, exp_, what);
  endtask

  task automatic mcuSend(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1; rxData = b;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic mcuTake(input logic [7:0] exp_);
    @(negedge clk);
    check(3, {31'b0, txValid}, 32'h1, "txValid before take");
    check(3, {24'b0, txData}, {24'b0, exp_}, "txData order");
    txReady = 1'b1;
    @(negedge clk);
    txReady = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    idle(3);
    rstN = 1'b1;
    idle(1);
    check(2, {31'b0, txValid}, 32'h0, "txValid after reset");
    check(2, {31'b0, irq}, 32'h0, "irq after reset");

    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].isRead) begin
        busRead(VECS[i].addr, d);
        check(int'(VECS[i].req), d, VECS[i].expect_, $sformatf("vector %0d", i));
      end else begin
        busWrite(VECS[i].addr, VECS[i].wdata);
      end
    end
    check(10, {31'b0, irq}, 32'h0, "no request, irq low");

    // R3 drain order, then TXE rise latches request 0
    mcuTake(8'hA5);
    mcuTake(8'h5C);
    idle(2);
    check(3, {31'b0, txValid}, 32'h0, "tx drained");
    readCheck(3'd0, 32'hF1, 8, "R8 TXE request latched");
    check(10, {31'b0, irq}, 32'h1, "R10 irq with enabled request");
    busWrite(3'd2, 32'h1);
    readCheck(3'd0, 32'hF0, 9, "R9 W1C cleared request 0");
    check(9, {31'b0, irq}, 32'h0, "irq after clear");

    // R10 mask gating, R5 receive path
    busWrite(3'd0, 32'h00);
    mcuSend(8'h77);
    idle(2);
    readCheck(3'd0, 32'h04, 8, "R8 RXNE request latched");
    check(10, {31'b0, irq}, 32'h0, "masked request keeps irq low");
    busWrite(3'd0, 32'h40);
    idle(1);
    check(10, {31'b0, irq}, 32'h1, "enabled request raises irq");
    readCheck(3'd1, 32'h7700, 5, "R5 rx byte in 15:8");
    readCheck(3'd1, 32'h0, 5, "R5 empty after pop");
    busWrite(3'd2, 32'h4);
    readCheck(3'd0, 32'h40, 9, "R9 request 2 cleared");

    // R6 overflow
    for (int i = 0; i < 17; i++) mcuSend(8'h40 + 8'(i));
    idle(2);
    readCheck(3'd2, 32'hF, 6, "R6 status full with overflow");
    readCheck(3'd0, 32'h4C, 6, "R6 overflow request");
    busWrite(3'd2, 32'h4);
    readCheck(3'd2, 32'hF, 9, "R9 bit2 clear leaves overflow");
    for (int i = 0; i < 16; i++)
      readCheck(3'd1, {16'b0, 8'h40 + 8'(i), 8'b0}, 6, "R6 kept bytes in order");
    readCheck(3'd1, 32'h0, 6, "R6 seventeenth byte dropped");
    readCheck(3'd2, 32'hB, 7, "R7 overflow sticky when empty");
    busWrite(3'd2, 32'h8);
    readCheck(3'd2, 32'h3, 9, "R9 overflow cleared");

    // R4 tx full
    for (int i = 0; i < 17; i++) busWrite(3'd1, {16'b0, 8'h80 + 8'(i), 8'b0});
    readCheck(3'd2, 32'h0, 4, "R4 tx full status");
    for (int i = 0; i < 16; i++) mcuTake(8'h80 + 8'(i));
    idle(1);
    check(4, {31'b0, txValid}, 32'h0, "R4 write while full ignored");

    // R2 reset mid-traffic
    busWrite(3'd1, 32'h0000EE00);
    mcuSend(8'h11);
    busWrite(3'd0, 32'hF0);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    idle(1);
    check(2, {31'b0, txValid}, 32'h0, "reset empties tx");
    check(2, {31'b0, irq}, 32'h0, "reset irq low");
    readCheck(3'd2, 32'h3, 2, "reset status");
    readCheck(3'd0, 32'h0, 2, "reset intr");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule